// File: doc/BRIEF.md
# SRAM Window Register and Access Qualifier

This block sits between a processor bus and a small on-chip SRAM. It holds one configuration word with four parts: a base address for the SRAM window, a write-protect bit, five per-class mask bits and an enable bit. Every bus request carries an address, a direction and an access-class code. The block decides in the cycle of the request whether the access lands in the SRAM. A hit is served by the internal array. A miss goes out on the external path.

A masked access class is not a fault. Such an access is treated exactly like an address outside the window: it is forwarded to the external select with no error. After reset the enable bit is clear, so nothing hits and the array contents are undefined. Software typically writes the base address together with the enable bit first. It may later rewrite the word to change the protection and mask attributes.

Requests use a valid/ready handshake, and read data returns on a valid/ready response channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` drops while a read response is waiting and `rsp_ready` is low. A response that has not been accepted keeps its data stable until `rsp_ready` rises. The configuration port, the external select and the protect-error pulse are plain signals.

Top module: `sram_window`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and every accepted request asserts `ext_sel`.
- R2: While the enable bit (configuration bit 0) is 0, no request hits. Every accepted request asserts `ext_sel`, and no response and no `wp_err` follow.
- R3: A request hits only when all of these hold: the enable bit is 1; `req_addr[31:12]` equals configuration bits 31:12; and the class mask bit is 0.
- R4: The class codes on `req_space` are 0 for CPU space or interrupt acknowledge, 1 for supervisor code, 2 for supervisor data, 3 for user code and 4 for user data. The mask bit for class k is configuration bit 5−k. When that bit is 1, the request is forwarded to `ext_sel` with no `wp_err` and no response.
- R5: Class codes 5, 6 and 7 never hit. They always go to `ext_sel`.
- R6: When write protect (configuration bit 8) is 1, a write that hits leaves the array unchanged. `wp_err` is high for exactly the one cycle after the accepted write. Reads still hit and return data.
- R7: A read hit raises `rsp_valid` in the cycle after acceptance. `rsp_rdata` then holds the word at `req_addr[11:2]`. An unprotected write hit stores `req_wdata` at that word.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_rdata` hold and `req_ready` is 0.
- R9: `ext_sel` is high in the same cycle as an accepted miss and never for a hit.
- R10: `cfg_rdata` returns the written bits 31:12, 8 and 5:0. All other bits read 0.
- R11: Writing 0x20000001 enables the window at 0x20000000 with every class unmasked and no write protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | Access class code |
| req_wdata | input | 32 | Write data |
| ext_sel | output | 1 | Accepted request routed to external path |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Read response data |
| wp_err | output | 1 | One-cycle write-protect error pulse |

## Verification
The bench targets the following corner cases.
- Each of the five mask bits is set alone, and accesses of that class are sent in. A design with the bit order reversed would answer the wrong class from the SRAM.
- Class codes 5 to 7 are sent inside the window. A decoder that indexes the mask out of range would let them hit.
- Protected writes are followed by reads of the same word. A design that raises the error but still writes would return the new data.
- A stalled response is held over several cycles. A design that drops or overwrites it, or keeps accepting requests, shows a changed `rsp_valid`, changed data or a high `req_ready`.

// File: rtl/sram_win_pkg.sv
`timescale 1ns/1ps
package sram_win_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned WP_BIT     = 8;
  localparam int unsigned NUM_CLASS  = 5;
  // mask bit for class k sits at configuration bit MASK_TOP-k
  localparam int unsigned MASK_TOP   = 5;

  typedef enum logic [2:0] {
    SPC_CPU  = 3'd0,
    SPC_SUPC = 3'd1,
    SPC_SUPD = 3'd2,
    SPC_USRC = 3'd3,
    SPC_USRD = 3'd4
  } space_e;
endpackage

// File: rtl/sram_win_cfg.sv
`timescale 1ns/1ps
module sram_win_cfg
  import sram_win_pkg::*;
#(
  parameter int unsigned BASE_LSB = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [CFG_W-1:0]          wdata,
  output logic [CFG_W-1:0]          rdata,
  output logic                      en,
  output logic                      wp,
  output logic [NUM_CLASS-1:0]      mask,
  output logic [CFG_W-1-BASE_LSB:0] base
);
  localparam int unsigned BASE_W = CFG_W - BASE_LSB;

  logic              en_q, wp_q;
  logic [BASE_W-1:0] base_q;
  logic [NUM_CLASS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wp_q   <= 1'b0;
      base_q <= '0;
    end else if (we) begin
      en_q   <= wdata[EN_BIT];
      wp_q   <= wdata[WP_BIT];
      base_q <= wdata[CFG_W-1:BASE_LSB];
    end
  end

  for (genvar k = 0; k < NUM_CLASS; k++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q[k] <= 1'b0;
      else if (we) mask_q[k] <= wdata[MASK_TOP-k];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CFG_W-1:BASE_LSB] = base_q;
    rdata[WP_BIT] = wp_q;
    rdata[EN_BIT] = en_q;
    for (int k = 0; k < NUM_CLASS; k++) rdata[MASK_TOP-k] = mask_q[k];
  end

  assign en   = en_q;
  assign wp   = wp_q;
  assign mask = mask_q;
  assign base = base_q;

  // R10: a write is visible on the read-back port after the edge
  a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we) |-> rdata[CFG_W-1:BASE_LSB] == $past(wdata[CFG_W-1:BASE_LSB]));
endmodule

// File: rtl/sram_win_decode.sv
`timescale 1ns/1ps
module sram_win_decode
  import sram_win_pkg::*;
#(
  parameter int unsigned BASE_LSB = 12
) (
  input  logic [31:0]               addr,
  input  logic [2:0]                space,
  input  logic                      en,
  input  logic [NUM_CLASS-1:0]      mask,
  input  logic [CFG_W-1-BASE_LSB:0] base,
  output logic                      hit
);
  logic cls_ok;
  logic addr_ok;

  always_comb begin
    case (space)
      SPC_CPU:  cls_ok = !mask[0];
      SPC_SUPC: cls_ok = !mask[1];
      SPC_SUPD: cls_ok = !mask[2];
      SPC_USRC: cls_ok = !mask[3];
      SPC_USRD: cls_ok = !mask[4];
      default:  cls_ok = 1'b0;
    endcase
  end

  assign addr_ok = (addr[31:BASE_LSB] == base);
  assign hit     = en && cls_ok && addr_ok;
endmodule

// File: rtl/sram_win_array.sv
`timescale 1ns/1ps
module sram_win_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rd_q <= mem[idx];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/sram_window.sv
`timescale 1ns/1ps
module sram_window
  import sram_win_pkg::*;
#(
  parameter int unsigned BASE_LSB = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [2:0]  req_space,
  input  logic [31:0] req_wdata,
  output logic        ext_sel,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        wp_err
);
  localparam int unsigned AW = BASE_LSB - 2;

  logic                      c_en, c_wp;
  logic [NUM_CLASS-1:0]      c_mask;
  logic [CFG_W-1-BASE_LSB:0] c_base;
  logic                      hit, acc, arr_we, arr_re;
  logic                      rsp_q, wperr_q;

  sram_win_cfg #(.BASE_LSB(BASE_LSB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .en(c_en), .wp(c_wp), .mask(c_mask), .base(c_base)
  );

  sram_win_decode #(.BASE_LSB(BASE_LSB)) u_dec (
    .addr(req_addr), .space(req_space), .en(c_en), .mask(c_mask),
    .base(c_base), .hit(hit)
  );

  assign req_ready = !rsp_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign ext_sel   = acc && !hit;
  assign arr_we    = acc && hit && req_write && !c_wp;
  assign arr_re    = acc && hit && !req_write;

  sram_win_array #(.AW(AW), .DW(32)) u_arr (
    .clk(clk), .we(arr_we), .re(arr_re), .idx(req_addr[BASE_LSB-1:2]),
    .wdata(req_wdata), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      wperr_q <= 1'b0;
    end else begin
      if (arr_re)         rsp_q <= 1'b1;
      else if (rsp_ready) rsp_q <= 1'b0;
      wperr_q <= acc && hit && req_write && c_wp;
    end
  end

  assign rsp_valid = rsp_q;
  assign wp_err    = wperr_q;

  a_r2_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en |-> !hit);
  a_r5_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
    (req_space > 3'd4) |-> !hit);
  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    arr_re |=> rsp_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  a_r6_wp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err |-> $past(req_valid && req_write && c_wp));
  a_r9_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |=> !wp_err);
endmodule

// File: tb/sim_sram_window.sv
`timescale 1ns/1ps
module sim_sram_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [2:0]  req_space = '0;
  logic [31:0] req_wdata = '0;
  logic        ext_sel, rsp_valid, wp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] m_cfg = '0;
  logic [31:0] m_mem [1024];
  bit          m_known [1024];

  always #10 clk = ~clk;

  sram_window u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [31:0] a, input logic [2:0] sp);
    if (!m_cfg[0]) return 1'b0;
    if (sp > 3'd4) return 1'b0;
    if (m_cfg[5 - sp]) return 1'b0;
    return a[31:12] == m_cfg[31:12];
  endfunction

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    m_cfg = d & 32'hFFFF_F13F;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic [2:0] sp,
                        input bit w, input logic [31:0] d);
    bit h;
    int i;
    h = exp_hit(a, sp);
    i = int'(a[11:2]);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_space = sp; req_write = w; req_wdata = d;
    #1;
    chk({tag, " ext_sel"}, {31'd0, ext_sel}, {31'd0, !h});
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk({tag, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, h && !w});
    chk({tag, " wp_err"}, {31'd0, wp_err}, {31'd0, h && w && m_cfg[8]});
    if (h && !w && m_known[i]) chk({tag, " rdata"}, rsp_rdata, m_mem[i]);
    if (h && w && !m_cfg[8]) begin
      m_mem[i] = d; m_known[i] = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 1024; k++) m_known[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg", cfg_rdata, 32'h0);
    access("R1 reset access", 32'h0000_0010, 3'd2, 1'b0, 32'h0);
    access("R2 disabled write", 32'h2000_0004, 3'd4, 1'b1, 32'h5555_AAAA);

    // R11 enable at 0x2000_0000, nothing masked, no protect
    cfg_write(32'h2000_0001);
    chk("R11 readback", cfg_rdata, 32'h2000_0001);
    for (int c = 0; c < 5; c++)
      access("R11 write all classes", 32'h2000_0000 + 32'(c * 4), 3'(c), 1'b1, 32'hA000_0000 + 32'(c));
    for (int c = 0; c < 5; c++)
      access("R7 read back", 32'h2000_0000 + 32'(c * 4), 3'(c), 1'b0, 32'h0);
    access("R3 outside window", 32'h2000_1000, 3'd1, 1'b0, 32'h0);
    access("R3 top word", 32'h2000_0FFC, 3'd2, 1'b1, 32'hDEAD_BEEF);
    access("R3 top read", 32'h2000_0FFC, 3'd2, 1'b0, 32'h0);
    for (int c = 5; c < 8; c++)
      access("R5 bad class", 32'h2000_0000, 3'(c), 1'b0, 32'h0);

    // R4 each mask bit alone
    for (int c = 0; c < 5; c++) begin
      cfg_write(32'h2000_0001 | (32'h1 << (5 - c)));
      for (int s = 0; s < 5; s++)
        access("R4 mask class", 32'h2000_0008, 3'(s), 1'b0, 32'h0);
      access("R4 masked write", 32'h2000_0008, 3'(c), 1'b1, 32'h1111_2222);
    end

    // R10 unused bits read zero
    cfg_write(32'hFFFF_FFFF);
    chk("R10 readback all ones", cfg_rdata, 32'hFFFF_F13F);
    cfg_write(32'h2000_0100 | 32'h1);
    chk("R10 readback wp", cfg_rdata, 32'h2000_0101);

    // R6 write protect
    access("R6 protected write", 32'h2000_0004, 3'd2, 1'b1, 32'h0BAD_0BAD);
    access("R6 read after protect", 32'h2000_0004, 3'd2, 1'b0, 32'h0);
    cfg_write(32'h2000_0001);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h2000_0000; req_space = 3'd1; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R8 req_ready low", {31'd0, req_ready}, 32'd0);
    repeat (3) @(negedge clk);
    #1;
    chk("R8 rsp held", {31'd0, rsp_valid}, 32'd1);
    chk("R8 data held", rsp_rdata, m_mem[0]);
    rsp_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 rsp released", {31'd0, rsp_valid}, 32'd0);

    // R2 disable again
    cfg_write(32'h2000_0000);
    access("R2 disabled read", 32'h2000_0000, 3'd1, 1'b0, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      if (($urandom % 16) == 0) begin
        logic [31:0] cw;
        cw = ($urandom % 2) ? 32'h2000_0000 : 32'h4000_0000;
        cw = cw | ($urandom & 32'h0000_013E) | 32'(($urandom % 8) != 0);
        cfg_write(cw);
      end
      a = ($urandom % 2) ? {m_cfg[31:12], 10'($urandom), 2'b00} : ($urandom & 32'hFFFF_FFFC);
      access("R3 random", a, 3'($urandom), bit'($urandom), $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule